// File: doc/BRIEF.md
# Rectangle Fill and Copy Blitter

This block is a small 2D drawing engine that sits beside a linear frame buffer of 8-bit pixels. Software loads a handful of word registers: a line pitch, a fill colour, a raster-op request, two source corner points and two destination corner points. It then writes a command word that picks either a solid fill or a screen-to-screen copy, and the walk direction. The engine visits every pixel of the destination rectangle, one memory transaction at a time, over a request/acknowledge memory port. While it works it reports busy, and software polls the status word until busy drops.

A fill writes the colour into each pixel, or, when the raster-op request is non-zero, reads each pixel and writes it back XORed with the colour. A copy reads a source pixel and writes it to the matching destination pixel. When source and destination overlap, software picks the walk direction. It walks forward (top-left first) when the source lies below the destination, or on the same row and to its right. Otherwise it walks backward (bottom-right first) and loads the bottom-right points into the first corner registers. Each rectangle is described by two inclusive corners, so a zero-width or zero-height request leaves the end corner behind the start corner. Such a request finishes without touching memory.

State machine: `S_IDLE` (waiting), `S_RD_SRC` (reading a source pixel), `S_RD_DST` (reading a destination pixel for XOR), `S_WR` (writing a destination pixel), `S_FINISH` (one closing busy cycle). The transitions are as follows:
- `S_IDLE` moves on an accepted command: to `S_FINISH` if the rectangle is empty, otherwise to `S_RD_SRC` (copy), `S_RD_DST` (XOR fill) or `S_WR` (plain fill).
- `S_RD_SRC` and `S_RD_DST` move to `S_WR` on acknowledge.
- `S_WR` moves on acknowledge, to `S_FINISH` after the last pixel and otherwise back to the opening state of the operation.
- `S_FINISH` always returns to `S_IDLE`.

Top module: `rect_blitter`

## Requirements
- R1: Register word addresses are 0 pitch, 1 colour, 2 raster-op request, 3 source corner A, 4 source corner B, 5 destination corner A, 6 destination corner B, 7 command (write) / status (read). Corner registers hold y in bits 31:16 and x in bits 15:0, and read back as written.
- R2: The pitch register keeps bits 31:20 only (the pitch in units of 8 pixels), and reads back with bits 19:0 zero. A pixel at (x, y) lives at byte address y*pitch*8 + x, using the pitch held when the command was accepted.
- R3: A fill (command bit 1 = 0) with a raster-op request of zero writes the colour's low 8 bits to every destination pixel and issues no reads.
- R4: A fill with a non-zero raster-op request reads each destination pixel and writes back that value XOR the colour.
- R5: A copy (command bit 1 = 1) reads each source pixel before writing it to the destination. With command bit 0 = 0 it walks rows top to bottom and pixels left to right, from corner A (top-left) to corner B (bottom-right), so a source to the right on the same row lands exactly.
- R6: With command bit 0 = 1, corner A of both source and destination is the bottom-right point and corner B the top-left. The walk runs bottom row first, right to left, so a source lying above an overlapping destination lands exactly.
- R7: A rectangle whose corner B lies behind corner A in x or y (for the chosen direction) makes no memory access and keeps busy high for exactly one cycle.
- R8: Busy (status bit 31 and the busy port) is high from the clock edge that accepts a command. It stays high through the operation and for exactly one cycle after the cycle of the last write acknowledge.
- R9: A command written while busy is ignored: it starts nothing and causes no memory access.
- R10: A memory request holds its address, write flag and write data stable until the cycle in which it is acknowledged; read data is taken in that cycle.
- R11: After reset the engine is idle, busy is low, no request is made and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read word address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| busy | output | 1 | Engine busy |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Pixel byte address |
| mem_wdata | output | PIX_W | Pixel write data |
| mem_rdata | input | PIX_W | Pixel read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The hardest case to reach is an overlapping copy in which the wrong walk order would read pixels that the engine has already overwritten. The stimulus shifts a rectangle one way along a row and another rectangle down by two rows, so that the two overlap. It snapshots memory beforehand and compares the destination with the original source image. Memory acknowledges are withheld on every third cycle during some operations, which stretches reads and writes and shows that requests hold steady. A second command is issued in the middle of a long stalled fill to show that it is dropped.

// File: rtl/blit_pkg.sv
package blit_pkg;
    localparam int COORD_W = 16;

    typedef struct packed {
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] x;
    } point_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_SRC,
        S_RD_DST,
        S_WR,
        S_FINISH
    } blit_state_e;

    localparam logic [2:0] RA_PITCH  = 3'd0;
    localparam logic [2:0] RA_COLOUR = 3'd1;
    localparam logic [2:0] RA_ROP    = 3'd2;
    localparam logic [2:0] RA_SRC_A  = 3'd3;
    localparam logic [2:0] RA_SRC_B  = 3'd4;
    localparam logic [2:0] RA_DST_A  = 3'd5;
    localparam logic [2:0] RA_DST_B  = 3'd6;
    localparam logic [2:0] RA_CMD    = 3'd7;

    localparam int CMD_BACK_BIT  = 0;
    localparam int CMD_COPY_BIT  = 1;
    localparam int STAT_BUSY_BIT = 31;
    localparam int PITCH_LSB     = 20;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
    import blit_pkg::*;
#(
    parameter int PITCH_W = 12,
    parameter int PIX_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               busy,
    input  logic [2:0]         rd_addr,
    output logic [31:0]        rd_data,
    output logic [PITCH_W-1:0] pitch_units,
    output logic [PIX_W-1:0]   colour,
    output logic               rop_nz,
    output point_t             src_a,
    output point_t             dst_a,
    output point_t             dst_b,
    output logic               cmd_fire,
    output logic               cmd_copy,
    output logic               cmd_back
);
    localparam int PITCH_MSB = PITCH_LSB + PITCH_W - 1;

    logic [PITCH_W-1:0] pitch_q;
    logic [31:0]        colour_q;
    logic [31:0]        rop_q;
    point_t             src_a_q, src_b_q, dst_a_q, dst_b_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pitch_q  <= '0;
            colour_q <= '0;
            rop_q    <= '0;
            src_a_q  <= '0;
            src_b_q  <= '0;
            dst_a_q  <= '0;
            dst_b_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_PITCH:  pitch_q  <= wr_data[PITCH_MSB:PITCH_LSB];
                RA_COLOUR: colour_q <= wr_data;
                RA_ROP:    rop_q    <= wr_data;
                RA_SRC_A:  src_a_q  <= wr_data;
                RA_SRC_B:  src_b_q  <= wr_data;
                RA_DST_A:  dst_a_q  <= wr_data;
                RA_DST_B:  dst_b_q  <= wr_data;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            RA_PITCH:  rd_data = 32'(pitch_q) << PITCH_LSB;
            RA_COLOUR: rd_data = colour_q;
            RA_ROP:    rd_data = rop_q;
            RA_SRC_A:  rd_data = src_a_q;
            RA_SRC_B:  rd_data = src_b_q;
            RA_DST_A:  rd_data = dst_a_q;
            RA_DST_B:  rd_data = dst_b_q;
            default:   rd_data = 32'(busy) << STAT_BUSY_BIT;
        endcase
    end

    assign pitch_units = pitch_q;
    assign colour      = colour_q[PIX_W-1:0];
    assign rop_nz      = |rop_q;
    assign src_a       = src_a_q;
    assign dst_a       = dst_a_q;
    assign dst_b       = dst_b_q;
    assign cmd_fire    = wr_en && (wr_addr == RA_CMD) && !busy;
    assign cmd_copy    = wr_data[CMD_COPY_BIT];
    assign cmd_back    = wr_data[CMD_BACK_BIT];
endmodule

// File: rtl/blit_walker.sv
module blit_walker
    import blit_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  logic   adv,
    input  logic   backward,
    input  point_t src_start,
    input  point_t dst_a,
    input  point_t dst_b,
    output point_t src_cur,
    output point_t dst_cur,
    output logic   last,
    output logic   empty
);
    logic               bwd_q;
    logic [COORD_W-1:0] span_x, span_y;
    logic [COORD_W-1:0] span_x_q, col_q, row_q, src_x0_q, dst_x0_q;
    point_t             src_q, dst_q;

    function automatic logic [COORD_W-1:0] step(input logic [COORD_W-1:0] v, input logic back);
        return back ? v - 1'b1 : v + 1'b1;
    endfunction

    always_comb begin
        if (backward) begin
            span_x = dst_a.x - dst_b.x;
            span_y = dst_a.y - dst_b.y;
            empty  = (dst_a.x < dst_b.x) || (dst_a.y < dst_b.y);
        end else begin
            span_x = dst_b.x - dst_a.x;
            span_y = dst_b.y - dst_a.y;
            empty  = (dst_b.x < dst_a.x) || (dst_b.y < dst_a.y);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bwd_q    <= 1'b0;
            span_x_q <= '0;
            col_q    <= '0;
            row_q    <= '0;
            src_x0_q <= '0;
            dst_x0_q <= '0;
            src_q    <= '0;
            dst_q    <= '0;
        end else if (load) begin
            bwd_q    <= backward;
            span_x_q <= span_x;
            col_q    <= span_x;
            row_q    <= span_y;
            src_x0_q <= src_start.x;
            dst_x0_q <= dst_a.x;
            src_q    <= src_start;
            dst_q    <= dst_a;
        end else if (adv) begin
            if (col_q != '0) begin
                col_q   <= col_q - 1'b1;
                src_q.x <= step(src_q.x, bwd_q);
                dst_q.x <= step(dst_q.x, bwd_q);
            end else begin
                col_q   <= span_x_q;
                row_q   <= row_q - 1'b1;
                src_q.x <= src_x0_q;
                dst_q.x <= dst_x0_q;
                src_q.y <= step(src_q.y, bwd_q);
                dst_q.y <= step(dst_q.y, bwd_q);
            end
        end
    end

    assign src_cur = src_q;
    assign dst_cur = dst_q;
    assign last    = (col_q == '0) && (row_q == '0);
endmodule

// File: rtl/blit_addr.sv
module blit_addr
    import blit_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int PITCH_W = 12
) (
    input  point_t             pt,
    input  logic [PITCH_W-1:0] pitch_units,
    output logic [ADDR_W-1:0]  addr
);
    localparam int PROD_W = COORD_W + PITCH_W + 3;

    logic [PROD_W-1:0] row_base;
    logic [PROD_W-1:0] full;

    assign row_base = PROD_W'(pt.y) * PROD_W'({pitch_units, 3'b000});
    assign full     = row_base + PROD_W'(pt.x);
    assign addr     = full[ADDR_W-1:0];
endmodule

// File: rtl/rect_blitter.sv
module rect_blitter
    import blit_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int PITCH_W = 12,
    parameter int PIX_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [2:0]        reg_rd_addr,
    output logic [31:0]       reg_rd_data,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic [PIX_W-1:0]  mem_rdata,
    input  logic              mem_ack
);
    blit_state_e        state_q, state_d;
    logic [PITCH_W-1:0] pitch_units, pitch_q;
    logic [PIX_W-1:0]   colour, colour_q, pix_q;
    logic               rop_nz, cmd_fire, cmd_copy, cmd_back;
    logic               copy_q, xor_q;
    point_t             src_a, dst_a, dst_b, src_cur, dst_cur;
    logic               walk_last, walk_empty, walk_adv;
    logic [ADDR_W-1:0]  src_addr, dst_addr;

    blit_regs #(.PITCH_W(PITCH_W), .PIX_W(PIX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .busy(busy), .rd_addr(reg_rd_addr),
        .rd_data(reg_rd_data), .pitch_units(pitch_units), .colour(colour),
        .rop_nz(rop_nz), .src_a(src_a), .dst_a(dst_a), .dst_b(dst_b),
        .cmd_fire(cmd_fire), .cmd_copy(cmd_copy), .cmd_back(cmd_back)
    );

    blit_walker u_walk (
        .clk(clk), .rst_n(rst_n), .load(cmd_fire), .adv(walk_adv),
        .backward(cmd_back), .src_start(src_a), .dst_a(dst_a), .dst_b(dst_b),
        .src_cur(src_cur), .dst_cur(dst_cur), .last(walk_last), .empty(walk_empty)
    );

    blit_addr #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_src_addr (
        .pt(src_cur), .pitch_units(pitch_q), .addr(src_addr)
    );

    blit_addr #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_dst_addr (
        .pt(dst_cur), .pitch_units(pitch_q), .addr(dst_addr)
    );

    function automatic blit_state_e first_state(input logic is_copy, input logic is_xor);
        if (is_copy)     return S_RD_SRC;
        else if (is_xor) return S_RD_DST;
        else             return S_WR;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // operation context latched at command time, read data on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copy_q   <= 1'b0;
            xor_q    <= 1'b0;
            colour_q <= '0;
            pitch_q  <= '0;
            pix_q    <= '0;
        end else begin
            if (cmd_fire) begin
                copy_q   <= cmd_copy;
                xor_q    <= !cmd_copy && rop_nz;
                colour_q <= colour;
                pitch_q  <= pitch_units;
            end
            if ((state_q == S_RD_SRC || state_q == S_RD_DST) && mem_ack)
                pix_q <= mem_rdata;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_fire)
                    state_d = walk_empty ? S_FINISH
                                         : first_state(cmd_copy, !cmd_copy && rop_nz);
            end
            S_RD_SRC, S_RD_DST: begin
                if (mem_ack) state_d = S_WR;
            end
            S_WR: begin
                if (mem_ack)
                    state_d = walk_last ? S_FINISH : first_state(copy_q, xor_q);
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        mem_req   = (state_q == S_RD_SRC) || (state_q == S_RD_DST) || (state_q == S_WR);
        mem_we    = (state_q == S_WR);
        mem_addr  = (state_q == S_RD_SRC) ? src_addr : dst_addr;
        walk_adv  = (state_q == S_WR) && mem_ack && !walk_last;
        if (copy_q)     mem_wdata = pix_q;
        else if (xor_q) mem_wdata = pix_q ^ colour_q;
        else            mem_wdata = colour_q;
    end
endmodule

// File: rtl/blit_checker.sv
module blit_checker #(
    parameter int ADDR_W = 20,
    parameter int PIX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [PIX_W-1:0]  mem_wdata,
    input logic              op_copy,
    input logic              op_xor
);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_req_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd7 && !busy) |=> busy);

    assert_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(mem_req));

    assert_fill_noread_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !op_copy && !op_xor) |-> mem_we);
endmodule

bind rect_blitter blit_checker #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .busy(busy), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .op_copy(copy_q), .op_xor(xor_q)
);

// File: tb/sim_rect_blitter.sv
module sim_rect_blitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        busy, mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ack = 1'b1;

    logic [7:0] bmem [0:4095];
    logic [7:0] refm [0:4095];
    logic [7:0] snap [0:4095];

    int n_chk = 0, n_err = 0, cyc = 0, fin_cnt = 0;
    bit exp_busy = 0, mon_on = 0, stall = 0;
    int q_addr[$];
    int q_data[$];
    logic [31:0] m_pitch = 0, m_col = 0, m_rop = 0, m_sa = 0, m_da = 0, m_db = 0;

    always #10 clk = ~clk;

    assign mem_rdata = bmem[mem_addr[11:0]];

    rect_blitter u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pt(input int x, input int y);
        return {y[15:0], x[15:0]};
    endfunction

    // per-clock reference comparison
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(0, "R8", "watchdog expired", cyc, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
        if (fin_cnt > 0) begin
            fin_cnt--;
            if (fin_cnt == 0) exp_busy = 0;
        end
        if (mon_on) chk(busy == exp_busy, "R8", "busy per cycle", busy, exp_busy);
        mem_ack = stall ? ((cyc % 3) != 0) : 1'b1;
        #1;
        if (mon_on && mem_req && mem_ack) begin
            if (q_addr.size() == 0) begin
                chk(0, "R7/R9", "unexpected memory access", mem_addr, 0);
            end else if (mem_we) begin
                chk(mem_addr == q_addr[0], "R5", "write address", mem_addr, q_addr[0]);
                chk(mem_wdata == q_data[0], "R4", "write data", mem_wdata, q_data[0]);
                bmem[mem_addr[11:0]] = mem_wdata;
                void'(q_addr.pop_front());
                void'(q_data.pop_front());
                if (q_addr.size() == 0) fin_cnt = 2;
            end
        end
    end

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        case (a)
            3'd0: m_pitch = d;
            3'd1: m_col = d;
            3'd2: m_rop = d;
            3'd3: m_sa = d;
            3'd5: m_da = d;
            3'd6: m_db = d;
            default: ;
        endcase
        @(negedge clk); #2 reg_wr = 0;
    endtask

    task automatic rdchk(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); #2 reg_rd_addr = a;
        #1 chk(reg_rd_data == exp, req, "register read", reg_rd_data, exp);
    endtask

    // behavioural model of one command: fills queue and updates refm
    task automatic build(input logic [31:0] cmd, output bit is_empty);
        int ax, ay, bx, by, sx0, sy0, w, h, st, p;
        bit back, copy;
        back = cmd[0]; copy = cmd[1];
        ax = m_da[15:0]; ay = m_da[31:16]; bx = m_db[15:0]; by = m_db[31:16];
        sx0 = m_sa[15:0]; sy0 = m_sa[31:16];
        st = back ? -1 : 1;
        w = back ? ax - bx + 1 : bx - ax + 1;
        h = back ? ay - by + 1 : by - ay + 1;
        p = m_pitch[31:20] * 8;
        is_empty = (w <= 0) || (h <= 0);
        if (!is_empty) begin
            for (int r = 0; r < h; r++) begin
                for (int c = 0; c < w; c++) begin
                    int da, sa, v;
                    da = (ay + st*r) * p + (ax + st*c);
                    sa = (sy0 + st*r) * p + (sx0 + st*c);
                    if (copy) v = refm[sa];
                    else if (m_rop != 0) v = refm[da] ^ m_col[7:0];
                    else v = m_col[7:0];
                    refm[da] = v[7:0];
                    q_addr.push_back(da);
                    q_data.push_back(v);
                end
            end
        end
    endtask

    task automatic go(input logic [31:0] cmd, input bit stl);
        bit e;
        @(negedge clk); #2;
        stall = stl;
        if (!exp_busy) begin
            build(cmd, e);
            exp_busy = 1;
            if (e) fin_cnt = 2;
        end
        reg_wr = 1; reg_addr = 3'd7; reg_wdata = cmd;
        @(negedge clk); #2 reg_wr = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); #3;
            if (!busy && !exp_busy) return;
        end
        chk(0, "R8", "busy never cleared", busy, 0);
    endtask

    task automatic memchk(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < 4096; i++) if (bmem[i] !== refm[i]) bad++;
        chk(bad == 0, req, "frame buffer mismatches", bad, 0);
        chk(q_addr.size() == 0, req, "writes outstanding", q_addr.size(), 0);
    endtask

    task automatic cmpcopy(input int sx, input int sy, input int dx, input int dy,
                           input int w, input int h, input string req);
        int bad;
        bad = 0;
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                if (bmem[(dy+r)*16 + dx + c] !== snap[(sy+r)*16 + sx + c]) bad++;
        chk(bad == 0, req, "copied image mismatches", bad, 0);
    endtask

    task automatic take_snap();
        for (int i = 0; i < 4096; i++) snap[i] = bmem[i];
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            bmem[i] = 8'((i * 7 + 3) & 255);
            refm[i] = bmem[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #3;
        // R11 reset state
        chk(busy == 0, "R11", "busy after reset", busy, 0);
        chk(mem_req == 0, "R11", "request after reset", mem_req, 0);
        rdchk(3'd0, 32'h0, "R11");
        rdchk(3'd5, 32'h0, "R11");
        rdchk(3'd7, 32'h0, "R11");
        mon_on = 1;

        // R2 pitch field, R1 packing
        wreg(3'd0, 32'h0020_0000 | 32'h0001_2345);
        rdchk(3'd0, 32'h0020_0000, "R2");
        wreg(3'd3, pt(9, 5));
        rdchk(3'd3, 32'h0005_0009, "R1");
        wreg(3'd6, pt(300, 2));
        rdchk(3'd6, 32'h0002_012C, "R1");

        // R3 plain fill
        wreg(3'd1, 32'h0000_115A);
        wreg(3'd2, 32'h0);
        wreg(3'd5, pt(2, 1));
        wreg(3'd6, pt(6, 3));
        go(32'h0, 0);
        wait_idle();
        memchk("R3");

        // R4 XOR fill with stalls
        wreg(3'd1, 32'h0000_00FF);
        wreg(3'd2, 32'h1);
        wreg(3'd5, pt(4, 2));
        wreg(3'd6, pt(8, 5));
        go(32'h0, 1);
        wait_idle();
        memchk("R4");

        // R5 forward overlapping copy, source to the right on the same rows
        take_snap();
        wreg(3'd3, pt(4, 8));
        wreg(3'd5, pt(2, 8));
        wreg(3'd6, pt(7, 10));
        go(32'h2, 0);
        wait_idle();
        memchk("R5");
        cmpcopy(4, 8, 2, 8, 6, 3, "R5");

        // R6 backward overlapping copy, source above destination
        take_snap();
        wreg(3'd3, pt(6, 8));
        wreg(3'd5, pt(6, 10));
        wreg(3'd6, pt(3, 7));
        go(32'h3, 1);
        wait_idle();
        memchk("R6");
        cmpcopy(3, 5, 3, 7, 4, 4, "R6");

        // R7 empty rectangle
        wreg(3'd5, pt(5, 5));
        wreg(3'd6, pt(4, 9));
        go(32'h0, 0);
        wait_idle();
        memchk("R7");

        // R9 command while busy, R8 status bit
        wreg(3'd1, 32'h33);
        wreg(3'd2, 32'h0);
        wreg(3'd5, pt(0, 12));
        wreg(3'd6, pt(15, 15));
        go(32'h0, 1);
        rdchk(3'd7, 32'h8000_0000, "R8");
        go(32'h2, 0);
        stall = 1;
        wait_idle();
        memchk("R9");
        rdchk(3'd7, 32'h0, "R8");

        // R2 different pitch (24 pixels)
        stall = 0;
        wreg(3'd0, 32'h0030_0000);
        wreg(3'd1, 32'h77);
        wreg(3'd5, pt(1, 20));
        wreg(3'd6, pt(3, 21));
        go(32'h0, 0);
        wait_idle();
        memchk("R2");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule